// File: doc/BRIEF.md
# Daughterboard Reference Clock Output

This block drives pin 0 of one daughterboard's general-purpose I/O bank. A 32-bit configuration word decides what that pin carries. While the enable bit is set, the pin carries a reference clock divided down from the master clock. While the enable bit is clear, the pin carries the ordinary general-purpose output bit, so the pin is free for normal I/O. Each daughterboard side gets its own instance.

The divider is a three-state machine. `ST_OFF` holds the clock low. `ST_LOW` and `ST_HIGH` are the two half-periods, and each lasts `divisor` master-clock cycles. The transitions are:

- **start**: `ST_OFF` to `ST_LOW`, taken when the block is enabled and the divisor is non-zero.
- **rise**: `ST_LOW` to `ST_HIGH`, taken at terminal count.
- **fall**: `ST_HIGH` to `ST_LOW`, taken at terminal count.
- **stop**: `ST_LOW` or `ST_HIGH` to `ST_OFF`, taken when the block is disabled or the divisor becomes zero.

A new divisor is picked up only at a phase boundary. This means no half-period ever has a length other than the old divisor or the new one. Pin 0 is registered, so the pin lags the divider state by one cycle.

Top module: `dbio_clkout`

## Requirements
- R1: After reset, `pin0_out` is 0 and `cfg_rdata` reads 0x00000000.
- R2: A write with `wr_en` high captures bit 7 as the enable and bits 6:0 as the divisor. `cfg_rdata[7:0]` returns those eight bits from the cycle after the write.
- R3: `cfg_rdata[31:8]` always reads zero, whatever was written there.
- R4: When enabled with divisor D (1..127), pin 0 is a clock with high and low phases of exactly D master cycles each.
- R5: Starting from the stopped state, the first rising edge on pin 0 appears D+2 clock edges after the edge that captured the enabling write.
- R6: When enabled with divisor 0, pin 0 stays low and ignores `gpio_out`.
- R7: When disabled, `pin0_out` equals the `gpio_out` value sampled at the previous clock edge.
- R8: A divisor written while the clock runs does not shorten the phase in progress. That phase completes at the old length, and every later phase uses the new length.
- R9: After a write that clears the enable, `pin0_out` follows `gpio_out` starting at the second clock edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; also the source of the divided clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 32 | Configuration word: bit 7 enable, bits 6:0 divisor |
| gpio_out | input | 1 | General-purpose output value for pin 0 |
| cfg_rdata | output | 32 | Configuration read-back; reserved bits are zero |
| pin0_out | output | 1 | Registered drive of daughterboard pin 0 |

## Verification
The hardest case to reach is a divisor change that lands in the middle of a running phase. The stimulus first waits for a rising edge on pin 0. It then counts samples inside that high phase and issues the rewrite on a known sample. This lets it check that the phase in progress still runs its full old length before the new length appears. The case is exercised in both directions, once moving to a longer divisor and once to a shorter one. Every divisor from 1 to 127 is also swept from the stopped state, checking the start latency and both phase lengths.

// File: rtl/dbio_clkout_pkg.sv
package dbio_clkout_pkg;
    localparam int DIV_W  = 7;
    localparam int EN_BIT = DIV_W;

    typedef struct packed {
        logic             en;
        logic [DIV_W-1:0] div;
    } clkcfg_t;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } divst_t;
endpackage

// File: rtl/dbio_cfg_reg.sv
module dbio_cfg_reg
    import dbio_clkout_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output clkcfg_t          cfg,
    output logic [REG_W-1:0] rdata
);
    localparam int RSVD_W = REG_W - DIV_W - 1;

    logic rsvd_unused;
    assign rsvd_unused = |wr_data[REG_W-1:EN_BIT+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            cfg.en  <= wr_data[EN_BIT];
            cfg.div <= wr_data[DIV_W-1:0];
        end
    end

    assign rdata = {{RSVD_W{1'b0}}, cfg.en, cfg.div};

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rdata)); // R2

    AST_CFG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rdata[EN_BIT:0] == $past(wr_data[EN_BIT:0])); // R2
endmodule

// File: rtl/dbio_clk_div.sv
module dbio_clk_div
    import dbio_clkout_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  clkcfg_t cfg,
    output logic    clk_div
);
    divst_t           state, state_nx;
    logic [DIV_W-1:0] cnt, cnt_nx;
    logic [DIV_W-1:0] act_div, act_div_nx;
    logic             run;
    logic             term;

    assign run  = cfg.en && (cfg.div != '0);
    assign term = (cnt == act_div - 1'b1);

    always_comb begin
        state_nx   = state;
        cnt_nx     = cnt;
        act_div_nx = act_div;
        unique case (state)
            ST_OFF: begin
                if (run) begin
                    state_nx   = ST_LOW;
                    cnt_nx     = '0;
                    act_div_nx = cfg.div;
                end
            end
            ST_LOW, ST_HIGH: begin
                if (!run) begin
                    state_nx = ST_OFF;
                    cnt_nx   = '0;
                end else if (term) begin
                    state_nx   = (state == ST_LOW) ? ST_HIGH : ST_LOW;
                    cnt_nx     = '0;
                    act_div_nx = cfg.div;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            default: begin
                state_nx = ST_OFF;
                cnt_nx   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_OFF;
            cnt     <= '0;
            act_div <= '0;
        end else begin
            state   <= state_nx;
            cnt     <= cnt_nx;
            act_div <= act_div_nx;
        end
    end

    always_comb begin
        clk_div = (state == ST_HIGH);
    end

    AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !clk_div); // R6

    AST_EDGE_AT_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_div != $past(clk_div)) && $past(run) |-> $past(cnt) == $past(act_div) - 1'b1); // R4

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_OFF) |-> (cnt < act_div)); // R8
endmodule

// File: rtl/dbio_clkout.sv
module dbio_clkout
    import dbio_clkout_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             gpio_out,
    output logic [REG_W-1:0] cfg_rdata,
    output logic             pin0_out
);
    clkcfg_t cfg;
    logic    clk_div;

    dbio_cfg_reg #(.REG_W(REG_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg),
        .rdata   (cfg_rdata)
    );

    dbio_clk_div u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (cfg),
        .clk_div (clk_div)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin0_out <= 1'b0;
        else        pin0_out <= cfg.en ? clk_div : gpio_out;
    end

    AST_GPIO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |=> pin0_out == $past(gpio_out)); // R7

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cfg_rdata[REG_W-1:EN_BIT+1] == '0); // R3
endmodule

// File: tb/dbio_clkout_bench.sv
module dbio_clkout_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        gpio_out = 1'b0;
    logic [31:0] cfg_rdata;
    logic        pin0_out;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    dbio_clkout u_dbio_clkout (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .gpio_out(gpio_out), .cfg_rdata(cfg_rdata), .pin0_out(pin0_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            summary();
        end
    end

    // drive at a negedge; captured at the following posedge; returns at the next negedge
    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_len(input logic lvl, output int n);
        n = 1;
        forever begin
            @(negedge clk);
            if (pin0_out !== lvl) break;
            n++;
        end
    endtask

    task automatic midrun(input int d1, input int d2, input string req);
        int h, n;
        wr(32'h80 | d1);
        do @(negedge clk); while (pin0_out !== 1'b1);
        h = 1;
        @(negedge clk); if (pin0_out === 1'b1) h++;
        wr_en = 1'b1;
        wr_data = 32'h80 | d2;
        @(negedge clk); if (pin0_out === 1'b1) h++;
        wr_en = 1'b0;
        while (1) begin
            @(negedge clk);
            if (pin0_out !== 1'b1) break;
            h++;
        end
        chk({req, " old phase kept"}, h, d1);
        run_len(1'b0, n); chk({req, " new low"}, n, d2);
        run_len(1'b1, n); chk({req, " new high"}, n, d2);
        wr(32'h0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int n, k;
        repeat (3) @(negedge clk);
        chk("R1 pin0 in reset", pin0_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pin0", pin0_out, 0);
        chk("R1 rdata", cfg_rdata, 0);

        wr(32'h0000_0033);
        chk("R2 readback", cfg_rdata, 32'h33);
        wr(32'h0000_0085);
        chk("R2 readback en", cfg_rdata, 32'h85);
        wr(32'hFFFF_FF85);
        chk("R3 reserved zero", cfg_rdata, 32'h85);
        wr(32'hA5A5_A500);
        chk("R3 reserved zero 2", cfg_rdata, 32'h00);
        repeat (3) @(negedge clk);

        // R7: gpio pass-through when disabled
        for (int i = 0; i < 8; i++) begin
            gpio_out = logic'((i * 5 + 1) % 3 == 0);
            @(negedge clk);
            chk("R7 gpio pass", pin0_out, int'(gpio_out));
        end

        // R6: enabled with divisor 0
        wr(32'h80);
        for (int i = 0; i < 20; i++) begin
            gpio_out = logic'(i % 2);
            @(negedge clk);
            chk("R6 zero divisor low", pin0_out, 0);
        end
        wr(32'h00);
        repeat (3) @(negedge clk);

        // R4/R5 sweep over all divisors
        gpio_out = 1'b0;
        for (int d = 1; d < 128; d++) begin
            wr(32'h80 | d);
            k = 0;
            do begin @(negedge clk); k++; end while (pin0_out !== 1'b1 && k < 300);
            chk("R5 first rise latency", k, d + 2);
            run_len(1'b1, n); chk("R4 high phase", n, d);
            run_len(1'b0, n); chk("R4 low phase", n, d);
            run_len(1'b1, n); chk("R4 high phase 2", n, d);
            wr(32'h0);
            repeat (2) @(negedge clk);
        end

        // R9: disable while running returns pin to gpio
        wr(32'h84);
        repeat (13) @(negedge clk);
        gpio_out = 1'b1;
        wr(32'h00);
        @(negedge clk);
        chk("R9 pin follows gpio", pin0_out, 1);
        gpio_out = 1'b0;
        @(negedge clk);
        chk("R9 pin follows gpio low", pin0_out, 0);

        // R8: divisor change mid phase
        midrun(5, 9, "R8 longer");
        midrun(9, 3, "R8 shorter");

        summary();
    end
endmodule